// File: doc/BRIEF.md
# Programmable User Timing Pulse Generator

This block drives four user-defined timing lines from a shared pixel position and line position. Each position restarts when the leading edge of horizontal or vertical blanking arrives. Each channel carries its own horizontal window (start and stop pixel), vertical window (start and stop line), combine mode and output polarity. A channel can emit the horizontal window alone on every line. It can also merge the horizontal and vertical windows through AND, OR or XOR. With AND, for example, the pulse covers a pixel range on a chosen band of lines only.

The block has no data stream and so no valid/ready interface. The blanking edges are single-cycle strobes and the configuration inputs are plain levels. The configuration is held by the surrounding logic and is sampled on every pixel clock. The four outputs are registered.

Top module: `usr_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `user_out` is 1 after that edge, and the pixel and line counts return to 0.
- R2: A pixel clock edge that sees `hblank_lead` high loads the pixel count with 1; any other edge adds one. An edge that sees `vblank_lead` high loads the line count with 1; otherwise, an edge that sees `hblank_lead` high adds one to the line count. Both counts hold at their all-ones value.
- R3: With combine mode 0 (field value 0), a channel follows only its horizontal window, on every line, whatever its vertical window is.
- R4: When the start pixel is not 1, the horizontal window covers pixels start+1 through stop inclusive. When the start pixel is 1, it covers pixels 1 through stop. The window is empty when the lower bound exceeds stop, so a pulse can never begin on pixel 2.
- R5: With combine mode 1, a channel is active only where the horizontal window and the vertical window are both active.
- R6: With combine mode 2, a channel is active where either window is active.
- R7: With combine mode 3, a channel is active where exactly one of the two windows is active.
- R8: The vertical window covers lines from the start line through the stop line inclusive.
- R9: Polarity bit 0 makes the output low while active and high otherwise. Polarity bit 1 makes it high while active and low otherwise.
- R10: The output for a given pixel and line count appears one pixel clock edge after the edge that registered those counts. Two edges therefore separate a `hblank_lead` strobe and the output for pixel 1.
- R11: Channels are independent: each uses only its own slices of the configuration buses. Channel i uses bits `[i*W +: W]` of each start/stop bus, bits `[2*i +: 2]` of `cfg_mode` and bit i of `cfg_pol_high`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hblank_lead | input | 1 | One-cycle strobe at the leading edge of horizontal blanking |
| vblank_lead | input | 1 | One-cycle strobe at the leading edge of vertical blanking |
| cfg_h_start | input | N_CH*PIX_W | Start pixel per channel |
| cfg_h_stop | input | N_CH*PIX_W | Stop pixel per channel |
| cfg_v_start | input | N_CH*LINE_W | Start line per channel |
| cfg_v_stop | input | N_CH*LINE_W | Stop line per channel |
| cfg_mode | input | 2*N_CH | Combine mode per channel: 0 horizontal only, 1 AND, 2 OR, 3 XOR |
| cfg_pol_high | input | N_CH | Polarity per channel: 0 active low, 1 active high |
| user_out | output | N_CH | Registered user timing pulses |

## Verification
The assertions assume a synchronous reset that is held low across at least one rising edge. The pixel-2 check further assumes that the horizontal configuration, mode and polarity do not change between the cycle counting pixel 1 and the cycle counting pixel 2. The stimulus drives all inputs on the falling clock edge. It changes configuration only at the boundary between test phases, and it discards any pending expectations at that point. The blanking strobes are one cycle wide, with vertical strobes coinciding with a horizontal strobe, as real video timing produces them.

// File: rtl/upg_pkg.sv
package upg_pkg;
  typedef enum logic [1:0] {
    CMB_HONLY = 2'd0,
    CMB_AND   = 2'd1,
    CMB_OR    = 2'd2,
    CMB_XOR   = 2'd3
  } cmb_e;
endpackage

// File: rtl/upg_counters.sv
module upg_counters #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hblank_lead,
  input  logic              vblank_lead,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      if (hblank_lead)
        pix_cnt <= PIX_W'(1);
      else if (pix_cnt != PIX_MAX)
        pix_cnt <= pix_cnt + PIX_W'(1);

      if (vblank_lead)
        line_cnt <= LINE_W'(1);
      else if (hblank_lead && line_cnt != LINE_MAX)
        line_cnt <= line_cnt + LINE_W'(1);
    end
  end
endmodule

// File: rtl/upg_window.sv
module upg_window #(
  parameter int W          = 12,
  parameter bit SKIP_FIRST = 1'b0
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         in_win
);
  logic [W:0] lo_eff;

  generate
    if (SKIP_FIRST) begin : g_skip
      always_comb begin
        if (lo == W'(1))
          lo_eff = {1'b0, lo};
        else
          lo_eff = {1'b0, lo} + (W+1)'(1);
      end
    end else begin : g_plain
      always_comb lo_eff = {1'b0, lo};
    end
  endgenerate

  always_comb in_win = ({1'b0, pos} >= lo_eff) && (pos <= hi);
endmodule

// File: rtl/upg_channel.sv
module upg_channel
  import upg_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [PIX_W-1:0]  h_start,
  input  logic [PIX_W-1:0]  h_stop,
  input  logic [LINE_W-1:0] v_start,
  input  logic [LINE_W-1:0] v_stop,
  input  logic [1:0]        mode,
  input  logic              pol_high,
  output logic              pulse_q
);
  logic h_on, v_on, act;

  upg_window #(.W(PIX_W), .SKIP_FIRST(1'b1)) u_hwin (
    .pos(pix_cnt), .lo(h_start), .hi(h_stop), .in_win(h_on)
  );

  upg_window #(.W(LINE_W), .SKIP_FIRST(1'b0)) u_vwin (
    .pos(line_cnt), .lo(v_start), .hi(v_stop), .in_win(v_on)
  );

  always_comb begin
    case (cmb_e'(mode))
      CMB_AND: act = h_on & v_on;
      CMB_OR:  act = h_on | v_on;
      CMB_XOR: act = h_on ^ v_on;
      default: act = h_on;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pulse_q <= 1'b1;
    else
      pulse_q <= pol_high ? act : ~act;
  end
endmodule

// File: rtl/usr_pulse_gen.sv
module usr_pulse_gen #(
  parameter int N_CH   = 4,
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hblank_lead,
  input  logic                     vblank_lead,
  input  logic [N_CH*PIX_W-1:0]    cfg_h_start,
  input  logic [N_CH*PIX_W-1:0]    cfg_h_stop,
  input  logic [N_CH*LINE_W-1:0]   cfg_v_start,
  input  logic [N_CH*LINE_W-1:0]   cfg_v_stop,
  input  logic [2*N_CH-1:0]        cfg_mode,
  input  logic [N_CH-1:0]          cfg_pol_high,
  output logic [N_CH-1:0]          user_out
);
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;

  upg_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .hblank_lead(hblank_lead), .vblank_lead(vblank_lead),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      upg_channel #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .h_start(cfg_h_start[i*PIX_W +: PIX_W]),
        .h_stop(cfg_h_stop[i*PIX_W +: PIX_W]),
        .v_start(cfg_v_start[i*LINE_W +: LINE_W]),
        .v_stop(cfg_v_stop[i*LINE_W +: LINE_W]),
        .mode(cfg_mode[2*i +: 2]),
        .pol_high(cfg_pol_high[i]),
        .pulse_q(user_out[i])
      );
    end
  endgenerate
endmodule

// File: rtl/upg_checker.sv
module upg_checker #(
  parameter int N_CH   = 4,
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hblank_lead,
  input logic                   vblank_lead,
  input logic [PIX_W-1:0]       pix_cnt,
  input logic [LINE_W-1:0]      line_cnt,
  input logic [N_CH*PIX_W-1:0]  cfg_h_start,
  input logic [N_CH*PIX_W-1:0]  cfg_h_stop,
  input logic [2*N_CH-1:0]      cfg_mode,
  input logic [N_CH-1:0]        cfg_pol_high,
  input logic [N_CH-1:0]        user_out
);
  localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

  logic rst_edge = 1'b0;
  always @(posedge clk) rst_edge <= !rst_n;

  // R1: outputs idle high after an edge taken in reset
  always @(negedge clk) begin
    if (rst_edge)
      a_r1_reset_idle: assert (user_out == '1)
        else $error("a_r1_reset_idle");
  end

  a_r2_pix_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_lead |=> (pix_cnt == PIX_W'(1)));

  a_r2_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_lead |=> (line_cnt == LINE_W'(1)));

  a_r2_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!hblank_lead && pix_cnt != '0 && pix_cnt != PIX_MAX)
      |=> (pix_cnt == PIX_W'($past(pix_cnt) + 1'b1)));

  logic [N_CH-1:0] act;
  always_comb act = user_out ^ ~cfg_pol_high;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
      // R4: horizontal-only pulse never starts on pixel 2
      a_r4_no_pix2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt == PIX_W'(2) && cfg_mode[2*i +: 2] == 2'd0 &&
         $stable(cfg_h_start) && $stable(cfg_h_stop) &&
         $stable(cfg_mode) && $stable(cfg_pol_high))
          |=> (!act[i] || $past(act[i])));
    end
  endgenerate
endmodule

bind usr_pulse_gen upg_checker #(.N_CH(N_CH), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hblank_lead(hblank_lead), .vblank_lead(vblank_lead),
  .pix_cnt(pix_cnt), .line_cnt(line_cnt),
  .cfg_h_start(cfg_h_start), .cfg_h_stop(cfg_h_stop),
  .cfg_mode(cfg_mode), .cfg_pol_high(cfg_pol_high),
  .user_out(user_out)
);

// File: tb/test_usr_pulse_gen.sv
module test_usr_pulse_gen;
  localparam int N_CH   = 4;
  localparam int PIX_W  = 12;
  localparam int LINE_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb = 1'b0, vb = 1'b0;
  logic [N_CH*PIX_W-1:0]  h_start_v, h_stop_v;
  logic [N_CH*LINE_W-1:0] v_start_v, v_stop_v;
  logic [2*N_CH-1:0]      mode_v;
  logic [N_CH-1:0]        pol_v;
  logic [N_CH-1:0]        user_out;

  int hs [N_CH];
  int he [N_CH];
  int vs [N_CH];
  int ve [N_CH];
  int md [N_CH];
  int pl [N_CH];
  string tag [N_CH];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      h_start_v[i*PIX_W +: PIX_W]   = PIX_W'(hs[i]);
      h_stop_v[i*PIX_W +: PIX_W]    = PIX_W'(he[i]);
      v_start_v[i*LINE_W +: LINE_W] = LINE_W'(vs[i]);
      v_stop_v[i*LINE_W +: LINE_W]  = LINE_W'(ve[i]);
      mode_v[2*i +: 2]              = 2'(md[i]);
      pol_v[i]                      = pl[i][0];
    end
  end

  usr_pulse_gen #(.N_CH(N_CH), .PIX_W(PIX_W), .LINE_W(LINE_W)) i_usr_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hblank_lead(hb), .vblank_lead(vb),
    .cfg_h_start(h_start_v), .cfg_h_stop(h_stop_v),
    .cfg_v_start(v_start_v), .cfg_v_stop(v_stop_v),
    .cfg_mode(mode_v), .cfg_pol_high(pol_v), .user_out(user_out)
  );

  typedef struct {
    int    due;
    int    ch;
    logic  val;
    string tg;
  } exp_t;

  exp_t q [$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int mpix = 0, mline = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic model_out(int ch, int p, int l);
    logic hw, vw, a;
    int lo;
    lo = (hs[ch] == 1) ? 1 : hs[ch] + 1;
    hw = (p >= lo) && (p <= he[ch]);
    vw = (l >= vs[ch]) && (l <= ve[ch]);
    case (md[ch])
      1: a = hw & vw;
      2: a = hw | vw;
      3: a = hw ^ vw;
      default: a = hw;
    endcase
    return pl[ch] != 0 ? a : ~a;
  endfunction

  // driver: one pixel clock of stimulus, expectations pushed for two edges later
  task automatic step(input logic h, input logic v);
    exp_t e;
    @(negedge clk);
    hb = h;
    vb = v;
    if (h) mpix = 1; else mpix = mpix + 1;
    if (v) mline = 1; else if (h) mline = mline + 1;
    for (int c = 0; c < N_CH; c++) begin
      e.due = cyc + 2;
      e.ch  = c;
      e.val = model_out(c, mpix, mline);
      e.tg  = tag[c];
      q.push_back(e);
    end
  endtask

  task automatic run_line(input int len, input logic v);
    for (int i = 0; i < len; i++) step(i == 0, v && (i == 0));
  endtask

  task automatic set_cfg(input int c, input int a, input int b, input int x,
                         input int y, input int m, input int p, input string t);
    hs[c] = a; he[c] = b; vs[c] = x; ve[c] = y; md[c] = m; pl[c] = p; tag[c] = t;
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (user_out[e.ch] !== e.val) begin
        errors++;
        $display("FAIL %s ch%0d cyc %0d: got %b expected %b",
                 e.tg, e.ch, cyc, user_out[e.ch], e.val);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < N_CH; c++) set_cfg(c, 1, 3, 1, 2, c, c % 2, "R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < N_CH; c++) begin
      checks++;
      if (user_out[c] !== 1'b1) begin
        errors++;
        $display("FAIL R1 ch%0d: got %b expected 1", c, user_out[c]);
      end
    end
    rst_n = 1'b1;

    // phase A: horizontal-only windows, start offset, polarity
    q.delete();
    set_cfg(0, 1, 4, 2, 3, 0, 0, "R2 R3 R4 R10");
    set_cfg(1, 2, 6, 1, 1, 0, 0, "R4");
    set_cfg(2, 5, 10, 4, 9, 0, 1, "R9 R3");
    set_cfg(3, 8, 8, 1, 5, 0, 0, "R4 empty");
    run_line(16, 1'b1);
    repeat (4) run_line(16, 1'b0);
    run_line(12, 1'b1);
    run_line(12, 1'b0);

    // phase B: combine modes with vertical windows
    q.delete();
    set_cfg(0, 3, 9, 2, 4, 1, 0, "R5 R8");
    set_cfg(1, 1, 3, 3, 3, 2, 1, "R6 R8");
    set_cfg(2, 4, 12, 2, 5, 3, 0, "R7");
    set_cfg(3, 10, 14, 1, 2, 0, 1, "R11 R3");
    run_line(14, 1'b1);
    repeat (7) run_line(14, 1'b0);
    run_line(20, 1'b1);
    repeat (3) run_line(20, 1'b0);

    // phase C: swapped polarity and modes across channels
    q.delete();
    set_cfg(0, 2, 2, 1, 6, 2, 1, "R6 R4");
    set_cfg(1, 6, 11, 2, 3, 3, 0, "R7 R11");
    set_cfg(2, 1, 1, 3, 4, 1, 1, "R5 R4");
    set_cfg(3, 0, 5, 4, 4, 2, 0, "R6 R9");
    run_line(13, 1'b1);
    repeat (6) run_line(13, 1'b0);

    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule